// File: doc/BRIEF.md
# Vector Add-Across Reduction Unit

This block takes a 32-bit add-across-lanes instruction word together with the 128-bit value of its source vector register, and returns one scalar: the wrapped sum of every active lane. The lane width (8, 16 or 32 bits) and the operand width (64 or 128 bits) come from two fields of the word. The block also hands back the destination register index so that a writeback stage can place the result.

The word is checked against a fixed opcode pattern, and reserved width combinations are refused. A refused word still travels through the pipe and comes out with an undefined-instruction flag, a zero result and no write enable. The reduction runs in a two-stage pipeline with a single-cycle valid strobe and no backpressure. Every word takes the same number of cycles whatever the data, so the timing reveals nothing about the operand.

Top module: `addred_unit`

## Requirements
- R1: A word is accepted only if bit 31 = 0, bit 29 = 0, bits 28:24 = 01110, bits 21:17 = 11000, bits 16:12 = 11011 and bits 11:10 = 10. Any other word sets the undefined flag.
- R2: A size field (bits 23:22) of 11 sets the undefined flag.
- R3: Size 10 with Q (bit 30) = 0 sets the undefined flag. Size 10 with Q = 1 is legal and sums four 32-bit lanes.
- R4: Size 00 sums byte lanes modulo 2^8: 8 lanes when Q = 0, 16 lanes when Q = 1. Lane i is source bits [8i+7:8i].
- R5: Size 01 sums 16-bit lanes modulo 2^16: 4 lanes when Q = 0, 8 lanes when Q = 1.
- R6: Size 10 with Q = 1 sums the four 32-bit lanes modulo 2^32, with no saturation.
- R7: When Q = 0, source bits 127:64 have no effect on the result.
- R8: Result bits above the lane width are zero.
- R9: For a word with the undefined flag set, the result is zero and the write enable is low, while the valid strobe still appears.
- R10: Each cycle with in_valid high gives exactly one out_valid pulse two clock edges later, for any data and for back-to-back input. A cycle with in_valid low gives no pulse.
- R11: out_rd equals bits 4:0 of the word that produced the result.
- R12: After reset, out_valid and out_wr_en are low until a word is supplied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word and source are present this cycle |
| in_instr | input | 32 | Instruction word |
| in_src | input | 128 | Source vector register value |
| out_valid | output | 1 | Result present, two cycles after input |
| out_rd | output | 5 | Destination register index |
| out_result | output | 128 | Lane-width sum, zero-extended |
| out_undef | output | 1 | Word was refused (valid with out_valid) |
| out_wr_en | output | 1 | Write the result to the destination register |

## Verification
All-ones lanes in every legal arrangement drive each lane width to its wrap point, with different expected values for 8 and 16 byte lanes and for 4 and 8 halfword lanes. Narrow-operand words carry random upper halves, so any leak of the upper 64 bits changes the sum. Single-bit corruptions of the opcode and the two reserved width codes check the refusal path. A long random stream with gaps and back-to-back words, mixing all arrangements and random Rd values, checks that results, indices and strobes stay lined up with their inputs.

// File: rtl/addred_pkg.sv
package addred_pkg;
   typedef enum logic [1:0] {
      LANE_B = 2'd0,
      LANE_H = 2'd1,
      LANE_W = 2'd2,
      LANE_X = 2'd3
   } lane_e;

   typedef struct packed {
      logic       undef;
      logic       wide;
      lane_e      lane;
      logic [4:0] rd;
   } dec_s;
endpackage

// File: rtl/addred_decode.sv
module addred_decode
   import addred_pkg::*;
(
   input  logic [31:0] instr,
   output dec_s        dec
);
   logic       match;
   logic [1:0] sz;
   logic       q;
   logic       unused_rn;

   assign unused_rn = ^instr[9:5];
   assign sz        = instr[23:22];
   assign q         = instr[30];
   assign match     = (instr[31] == 1'b0) &&
                      (instr[29:24] == 6'b001110) &&
                      (instr[21:10] == 12'b110001101110);

   always_comb begin
      dec.rd    = instr[4:0];
      dec.wide  = q;
      dec.lane  = lane_e'(sz);
      dec.undef = !match || (sz == 2'b11) || (sz == 2'b10 && !q);
   end
endmodule

// File: rtl/addred_tree.sv
module addred_tree
   import addred_pkg::*;
#(
   parameter int VEC_W  = 128,
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_v,
   input  lane_e             lane,
   input  logic              wide,
   input  logic [VEC_W-1:0]  src,
   output logic              out_v,
   output logic [WORD_W-1:0] sum
);
   localparam int NW     = VEC_W / WORD_W;
   localparam int HALF   = NW / 2;
   localparam int NBYTE  = WORD_W / 8;
   localparam int NHALF  = WORD_W / 16;

   initial begin
      assert (WORD_W == 32) else $error("addred_tree: WORD_W must be 32");
      assert (VEC_W % (2 * WORD_W) == 0) else $error("addred_tree: VEC_W must be a multiple of 64");
   end

   logic [NW-1:0][WORD_W-1:0] part_d, part_q;
   logic                      v1;
   lane_e                     lane_q;

   // stage 1: per-word partial sums, already wrapped at the lane width
   for (genvar g = 0; g < NW; g++) begin : g_word
      logic [WORD_W-1:0] w, p;
      logic [7:0]        bsum;
      logic [15:0]       hsum;
      logic              act;

      assign w = src[g*WORD_W +: WORD_W];

      if (g < HALF) begin : g_low
         assign act = 1'b1;
      end else begin : g_high
         assign act = wide;
      end

      always_comb begin
         bsum = '0;
         for (int b = 0; b < NBYTE; b++) bsum = bsum + w[b*8 +: 8];
         hsum = '0;
         for (int h = 0; h < NHALF; h++) hsum = hsum + w[h*16 +: 16];
         case (lane)
            LANE_B:  p = WORD_W'(bsum);
            LANE_H:  p = WORD_W'(hsum);
            default: p = w;
         endcase
      end

      assign part_d[g] = act ? p : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         part_q <= '0;
         lane_q <= LANE_B;
         v1     <= 1'b0;
      end else begin
         part_q <= part_d;
         lane_q <= lane;
         v1     <= in_v;
      end
   end

   // stage 2: fold the words, then cut to the lane width
   logic [WORD_W-1:0] total, masked;
   always_comb begin
      total = '0;
      for (int i = 0; i < NW; i++) total = total + part_q[i];
      case (lane_q)
         LANE_B:  masked = {{(WORD_W-8){1'b0}},  total[7:0]};
         LANE_H:  masked = {{(WORD_W-16){1'b0}}, total[15:0]};
         default: masked = total;
      endcase
   end

   lane_e lane_o;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum    <= '0;
         out_v  <= 1'b0;
         lane_o <= LANE_B;
      end else begin
         sum    <= masked;
         out_v  <= v1;
         lane_o <= lane_q;
      end
   end

   p_byte_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_v && lane_o == LANE_B) |-> (sum[WORD_W-1:8] == '0));
   p_half_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_v && lane_o == LANE_H) |-> (sum[WORD_W-1:16] == '0));
   p_stage_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      in_v |=> v1);
endmodule

// File: rtl/addred_unit.sv
module addred_unit
   import addred_pkg::*;
#(
   parameter int VEC_W  = 128,
   parameter int WORD_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [31:0]      in_instr,
   input  logic [VEC_W-1:0] in_src,
   output logic             out_valid,
   output logic [4:0]       out_rd,
   output logic [VEC_W-1:0] out_result,
   output logic             out_undef,
   output logic             out_wr_en
);
   initial begin
      assert (VEC_W == 128) else $error("addred_unit: VEC_W must be 128");
   end

   dec_s              dec, s1_dec, o_dec;
   logic [WORD_W-1:0] sum;
   logic              tree_v;

   addred_decode u_dec (
      .instr (in_instr),
      .dec   (dec)
   );

   addred_tree #(.VEC_W(VEC_W), .WORD_W(WORD_W)) u_tree (
      .clk   (clk),
      .rst_n (rst_n),
      .in_v  (in_valid),
      .lane  (dec.lane),
      .wide  (dec.wide),
      .src   (in_src),
      .out_v (tree_v),
      .sum   (sum)
   );

   // sideband follows the tree stage by stage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_dec <= '0;
         o_dec  <= '0;
      end else begin
         s1_dec <= dec;
         o_dec  <= s1_dec;
      end
   end

   assign out_valid  = tree_v;
   assign out_rd     = o_dec.rd;
   assign out_undef  = tree_v && o_dec.undef;
   assign out_wr_en  = tree_v && !o_dec.undef;
   assign out_result = (tree_v && !o_dec.undef) ? {{(VEC_W-WORD_W){1'b0}}, sum} : '0;

   p_fixed_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ##2 out_valid);
   p_rd_carry_r11: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ##2 (out_rd == $past(in_instr[4:0], 2)));
   p_undef_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_undef) |-> (out_result == '0 && !out_wr_en));
   p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_result[VEC_W-1:WORD_W] == '0));
   p_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_instr[23:22] == 2'b11) |-> ##2 out_undef);
endmodule

// File: tb/sim_addred_unit.sv
module sim_addred_unit;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [31:0]  in_instr = '0;
   logic [127:0] in_src = '0;
   logic         out_valid;
   logic [4:0]   out_rd;
   logic [127:0] out_result;
   logic         out_undef;
   logic         out_wr_en;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   addred_unit u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
      .in_src(in_src), .out_valid(out_valid), .out_rd(out_rd),
      .out_result(out_result), .out_undef(out_undef), .out_wr_en(out_wr_en)
   );

   function automatic logic [31:0] mk(logic q, logic [1:0] sz, logic [4:0] rn, logic [4:0] rd);
      return {1'b0, q, 6'b001110, sz, 12'b110001101110, rn, rd};
   endfunction

   // reference: {undef, result}
   function automatic logic [128:0] model(logic [31:0] ins, logic [127:0] src);
      logic        bad;
      int          ew, n;
      logic [31:0] acc, mask;
      bad = (ins[31] != 1'b0) || (ins[29:24] != 6'b001110) || (ins[21:10] != 12'b110001101110)
            || (ins[23:22] == 2'b11) || (ins[23:22] == 2'b10 && !ins[30]);
      if (bad) return {1'b1, 128'b0};
      ew   = 8 << ins[23:22];
      n    = (64 << ins[30]) / ew;
      mask = (ew == 32) ? 32'hFFFF_FFFF : ((32'd1 << ew) - 32'd1);
      acc  = '0;
      for (int i = 0; i < n; i++) acc = acc + (32'((src >> (i*ew))) & mask);
      acc = acc & mask;
      return {1'b0, 96'b0, acc};
   endfunction

   function automatic string tag_of(logic [31:0] ins, logic [127:0] src);
      if (model(ins, src)[128]) begin
         if (ins[23:22] == 2'b11) return "R2";
         if (ins[23:22] == 2'b10 && ins[21:10] == 12'b110001101110) return "R3";
         return "R1";
      end
      if (!ins[30] && src[127:64] != '0) return "R7";
      case (ins[23:22])
         2'b00:   return "R4/R8";
         2'b01:   return "R5/R8";
         default: return "R6/R3";
      endcase
   endfunction

   task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // two-deep history of driven inputs
   logic         v1 = 0, v2 = 0;
   logic [31:0]  i1 = '0, i2 = '0;
   logic [127:0] s1 = '0, s2 = '0;

   task automatic step(logic v, logic [31:0] ins, logic [127:0] src);
      logic [128:0] m;
      @(negedge clk);
      chk(out_valid == v2, "R10", 128'(out_valid), 128'(v2));
      if (v2) begin
         m = model(i2, s2);
         chk(out_undef == m[128], tag_of(i2, s2), 128'(out_undef), 128'(m[128]));
         chk(out_wr_en == !m[128], "R9", 128'(out_wr_en), 128'(!m[128]));
         chk(out_result == m[127:0], tag_of(i2, s2), out_result, m[127:0]);
         chk(out_rd == i2[4:0], "R11", 128'(out_rd), 128'(i2[4:0]));
      end else begin
         chk(out_wr_en == 1'b0, "R10", 128'(out_wr_en), 128'd0);
      end
      v2 = v1; i2 = i1; s2 = s1;
      v1 = v;  i1 = ins; s1 = src;
      in_valid = v; in_instr = ins; in_src = src;
   endtask

   function automatic logic [127:0] rnd128();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   initial begin
      #(5 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R12", 128'(out_valid), 128'd0);
      chk(out_wr_en == 1'b0, "R12", 128'(out_wr_en), 128'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R12", 128'(out_valid), 128'd0);

      // directed: wrap points for every legal arrangement
      step(1, mk(0, 2'b00, 5'd1, 5'd3),  {128{1'b1}});   // 8B -> F8
      step(1, mk(1, 2'b00, 5'd2, 5'd4),  {128{1'b1}});   // 16B -> F0
      step(1, mk(0, 2'b01, 5'd3, 5'd5),  {128{1'b1}});   // 4H -> FFFC
      step(1, mk(1, 2'b01, 5'd4, 5'd6),  {128{1'b1}});   // 8H -> FFF8
      step(1, mk(1, 2'b10, 5'd5, 5'd7),  {128{1'b1}});   // 4S -> FFFFFFFC
      step(1, mk(0, 2'b00, 5'd6, 5'd8),  {64'hDEAD_BEEF_0123_4567, 64'h0});
      step(1, mk(0, 2'b01, 5'd7, 5'd9),  {64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0002_0003_0004});
      // refused words
      step(1, mk(1, 2'b11, 5'd8, 5'd10), rnd128());
      step(1, mk(0, 2'b11, 5'd8, 5'd11), rnd128());
      step(1, mk(0, 2'b10, 5'd9, 5'd12), rnd128());
      step(1, mk(1, 2'b00, 5'd9, 5'd13) ^ 32'h0000_8000, rnd128());
      step(1, mk(1, 2'b00, 5'd9, 5'd14) ^ 32'h8000_0000, rnd128());
      step(0, mk(1, 2'b10, 5'd0, 5'd15), rnd128());
      step(0, '0, '0);

      // constrained random stream
      for (int k = 0; k < 3000; k++) begin
         logic [31:0] ins;
         logic [1:0]  sz;
         logic        q;
         sz = 2'($urandom_range(0, 3));
         q  = 1'($urandom);
         ins = mk(q, sz, 5'($urandom), 5'($urandom));
         if ($urandom_range(0, 9) == 0) ins = ins ^ (32'd1 << $urandom_range(5, 31));
         step($urandom_range(0, 4) != 0, ins, rnd128());
      end
      step(0, '0, '0);
      step(0, '0, '0);
      step(0, '0, '0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule